// File: doc/BRIEF.md
# Stale line tracker

This block sits beside a private data cache. It lets the cache keep reading an invalidated line for a bounded time instead of dropping it at once. When an invalidation that carries a probe identifier arrives for a line held in the cache, the tracker records the line address, the probe and a countdown of `LIFETIME` cycles. Until that countdown runs out, a load to the line may use the old copy without speculation. The cache asks on every access whether a stale copy is still usable, and one cycle later it receives a yes or no answer.

An entry retires in one of four ways. Its countdown can reach zero. Its probe can be observed again on another incoming message. A critical-write heuristic can fire: a store-conditional access, or two back-to-back accesses with the same PC and address, which indicate polling. Finally, the table can be full when a new invalidation needs a slot. Retirements caused by the countdown, the probe or an eviction are reported to the cache on a single release channel that carries the address. Retirements caused by an access are reported through the miss answer to that same access. An invalidation for a line whose synchronisation bit is set, or for a line that is not in the cache, is applied at once and nothing is recorded.

Top module: `stale_line_tracker`

## Requirements
- R1: After reset the table is empty and `lk_valid`, `lk_stale`, `inv_done`, `inv_kept` and `rel_valid` are all 0. Every lookup misses.
- R2: An invalidation with `inv_present`=1 and `inv_sync`=0 allocates an entry. One cycle after it is sampled, `inv_done`=1 and `inv_kept`=1.
- R3: `lk_valid` is 1 exactly one cycle after each sampled access. Take an access sampled j clock edges after the edge that allocated its line. It reports `lk_stale`=1 when 1 <= j <= `LIFETIME` and no other rule retired the entry. Otherwise it reports 0.
- R4: An entry that is left alone produces one `rel_valid` pulse carrying its address, `LIFETIME`+1 cycles after its allocation edge. After that, lookups to the line miss.
- R5: A `probe_valid` whose `probe_id` equals an entry's probe expires that entry. A release pulse for it follows one cycle later. Entries holding other probes are unaffected.
- R6: An access with `acc_sc`=1 to a tracked line reports `lk_stale`=0 and frees the entry, so later lookups also miss.
- R7: If an access has the same `acc_pc` and `acc_addr` as the access just before it, it reports `lk_stale`=0 and frees the entry. Consecutive accesses that differ only in PC keep the line readable.
- R8: An invalidation with `inv_sync`=1 or `inv_present`=0 is not kept. It gives `inv_done`=1 and `inv_kept`=0, and the line then misses on lookup.
- R9: When every entry is valid and a new address is invalidated, the entry with the smallest remaining countdown is evicted. Its address is pulsed on `rel_valid`/`rel_addr` in the same cycle as `inv_done`, and the new line takes its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Incoming invalidation |
| inv_addr | input | ADDR_W | Line address of the invalidation |
| inv_probe | input | PROBE_W | Probe carried by the invalidation |
| inv_present | input | 1 | Line is currently held in the cache |
| inv_sync | input | 1 | Line's synchronisation bit (touched by store-conditional) |
| probe_valid | input | 1 | A probe was observed on another incoming message |
| probe_id | input | PROBE_W | Identifier of the observed probe |
| acc_valid | input | 1 | Cache access / lookup request |
| acc_pc | input | PC_W | PC of the accessing instruction |
| acc_addr | input | ADDR_W | Line address of the access |
| acc_sc | input | 1 | Access is a store-conditional |
| lk_valid | output | 1 | Lookup answer valid |
| lk_stale | output | 1 | Stale copy may be used |
| inv_done | output | 1 | Invalidation processed |
| inv_kept | output | 1 | Invalidated line is held stale |
| rel_valid | output | 1 | Stale line retired by countdown, probe or eviction |
| rel_addr | output | ADDR_W | Address of the retired line |

## Verification
Eviction on a full table is the hardest case to reach. It needs every entry valid at the same moment, and the victim must be told apart by its remaining countdown. The bench therefore issues back-to-back invalidations on consecutive cycles, so that the oldest entry holds a strictly smaller countdown than the others, and sends the extra invalidation well inside the lifetime window. The stale window is swept over every distance from zero up to past the lifetime. All four combinations of the present and sync bits are swept as well, using a four-entry table with a short lifetime.

// File: rtl/sst_pkg.sv
package sst_pkg;

    // Where an accepted invalidation finds its slot
    typedef enum logic [1:0] {
        SLOT_NONE  = 2'd0,
        SLOT_REUSE = 2'd1,
        SLOT_FREE  = 2'd2,
        SLOT_EVICT = 2'd3
    } slot_src_e;

endpackage

// File: rtl/sst_cam.sv
module sst_cam #(
    parameter int N = 128,
    parameter int W = 32
) (
    input  logic [W-1:0]        key,
    input  logic [N-1:0][W-1:0] tags,
    input  logic [N-1:0]        valid,
    output logic [N-1:0]        hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/sst_first.sv
module sst_first #(
    parameter int N  = 128,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/sst_victim.sv
module sst_victim #(
    parameter int N  = 128,
    parameter int TW = 15,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][TW-1:0] timers,
    output logic [IW-1:0]        idx
);
    logic [TW-1:0] best;

    always_comb begin
        idx  = '0;
        best = timers[0];
        for (int i = 1; i < N; i++) begin
            if (timers[i] < best) begin
                best = timers[i];
                idx  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/stale_line_tracker.sv
module stale_line_tracker
    import sst_pkg::*;
#(
    parameter int ENTRIES  = 128,
    parameter int ADDR_W   = 32,
    parameter int PROBE_W  = 8,
    parameter int PC_W     = 32,
    parameter int LIFETIME = 16384
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inv_valid,
    input  logic [ADDR_W-1:0]  inv_addr,
    input  logic [PROBE_W-1:0] inv_probe,
    input  logic               inv_present,
    input  logic               inv_sync,
    input  logic               probe_valid,
    input  logic [PROBE_W-1:0] probe_id,
    input  logic               acc_valid,
    input  logic [PC_W-1:0]    acc_pc,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               acc_sc,
    output logic               lk_valid,
    output logic               lk_stale,
    output logic               inv_done,
    output logic               inv_kept,
    output logic               rel_valid,
    output logic [ADDR_W-1:0]  rel_addr
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int TW = $clog2(LIFETIME + 1);
    localparam logic [TW-1:0] TMAX = TW'(LIFETIME);

    typedef struct packed {
        logic [ENTRIES-1:0]              valid;
        logic [ENTRIES-1:0][ADDR_W-1:0]  addr;
        logic [ENTRIES-1:0][PROBE_W-1:0] probe;
        logic [ENTRIES-1:0][TW-1:0]      timer;
        logic                            prev_v;
        logic [PC_W-1:0]                 prev_pc;
        logic [ADDR_W-1:0]               prev_addr;
        logic                            lk_v;
        logic                            lk_s;
        logic                            done;
        logic                            kept;
        logic                            rel_v;
        logic [ADDR_W-1:0]               rel_a;
    } state_t;

    state_t s_q, s_d;

    logic [ENTRIES-1:0] acc_hit, inv_hit, pend_mask, alloc_mask;
    logic               acc_any, inv_any, free_any, pend_any;
    logic [IW-1:0]      acc_idx, inv_idx, free_idx, pend_idx, vic_idx, slot_idx;
    logic               keep_inv, poll_hit, acc_keep;
    slot_src_e          slot_src;

    // Lookup and invalidation address compare
    sst_cam #(.N(ENTRIES), .W(ADDR_W)) u_cam_acc (
        .key(acc_addr), .tags(s_q.addr), .valid(s_q.valid), .hit(acc_hit)
    );
    sst_cam #(.N(ENTRIES), .W(ADDR_W)) u_cam_inv (
        .key(inv_addr), .tags(s_q.addr), .valid(s_q.valid), .hit(inv_hit)
    );

    sst_first #(.N(ENTRIES)) u_first_acc  (.req(acc_hit),    .any(acc_any),  .idx(acc_idx));
    sst_first #(.N(ENTRIES)) u_first_inv  (.req(inv_hit),    .any(inv_any),  .idx(inv_idx));
    sst_first #(.N(ENTRIES)) u_first_free (.req(~s_q.valid), .any(free_any), .idx(free_idx));
    sst_first #(.N(ENTRIES)) u_first_pend (.req(pend_mask),  .any(pend_any), .idx(pend_idx));

    sst_victim #(.N(ENTRIES), .TW(TW)) u_victim (.timers(s_q.timer), .idx(vic_idx));

    // Slot selection for an accepted invalidation
    always_comb begin
        keep_inv   = inv_valid && inv_present && !inv_sync;
        slot_src   = SLOT_NONE;
        slot_idx   = '0;
        alloc_mask = '0;
        if (keep_inv) begin
            if (inv_any) begin
                slot_src = SLOT_REUSE;
                slot_idx = inv_idx;
            end else if (free_any) begin
                slot_src = SLOT_FREE;
                slot_idx = free_idx;
            end else begin
                slot_src = SLOT_EVICT;
                slot_idx = vic_idx;
            end
            alloc_mask[slot_idx] = 1'b1;
        end
    end

    // Access classification
    always_comb begin
        poll_hit = acc_valid && s_q.prev_v && (acc_pc == s_q.prev_pc)
                   && (acc_addr == s_q.prev_addr);
        acc_keep = acc_valid && acc_any && (s_q.timer[acc_idx] != '0)
                   && !poll_hit && !acc_sc;
    end

    // Expired entries awaiting a release pulse
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            pend_mask[i] = s_q.valid[i] && (s_q.timer[i] == '0)
                           && !(acc_valid && acc_hit[i]) && !alloc_mask[i];
        end
    end

    // Next state
    always_comb begin
        s_d       = s_q;
        s_d.lk_v  = acc_valid;
        s_d.lk_s  = 1'b0;
        s_d.done  = inv_valid;
        s_d.kept  = keep_inv;
        s_d.rel_v = 1'b0;

        for (int i = 0; i < ENTRIES; i++) begin
            if (s_q.valid[i] && (s_q.timer[i] != '0)) begin
                s_d.timer[i] = s_q.timer[i] - 1'b1;
            end
            if (probe_valid && s_q.valid[i] && (s_q.probe[i] == probe_id)) begin
                s_d.timer[i] = '0;
            end
        end

        if (acc_valid) begin
            s_d.prev_v    = 1'b1;
            s_d.prev_pc   = acc_pc;
            s_d.prev_addr = acc_addr;
            s_d.lk_s      = acc_keep;
            if (acc_any && !acc_keep) begin
                s_d.valid[acc_idx] = 1'b0;
            end
        end

        if (inv_valid && !keep_inv && inv_any) begin
            s_d.valid[inv_idx] = 1'b0;
        end

        if (slot_src == SLOT_EVICT) begin
            s_d.rel_v = 1'b1;
            s_d.rel_a = s_q.addr[vic_idx];
        end else if (pend_any) begin
            s_d.rel_v           = 1'b1;
            s_d.rel_a           = s_q.addr[pend_idx];
            s_d.valid[pend_idx] = 1'b0;
        end

        if (slot_src != SLOT_NONE) begin
            s_d.valid[slot_idx] = 1'b1;
            s_d.addr[slot_idx]  = inv_addr;
            s_d.probe[slot_idx] = inv_probe;
            s_d.timer[slot_idx] = TMAX;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lk_valid  = s_q.lk_v;
    assign lk_stale  = s_q.lk_s;
    assign inv_done  = s_q.done;
    assign inv_kept  = s_q.kept;
    assign rel_valid = s_q.rel_v;
    assign rel_addr  = s_q.rel_a;

endmodule

// File: rtl/sst_checker.sv
module sst_checker #(
    parameter int ADDR_W = 32,
    parameter int PC_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv_valid,
    input logic              inv_present,
    input logic              inv_sync,
    input logic              acc_valid,
    input logic [PC_W-1:0]   acc_pc,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_sc,
    input logic              lk_valid,
    input logic              lk_stale,
    input logic              inv_done,
    input logic              inv_kept
);
    AST_LOOKUP_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> lk_valid); // R3

    AST_STALE_HAS_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        lk_stale |-> lk_valid); // R3

    AST_SC_NEVER_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_sc) |=> !lk_stale); // R6

    AST_POLL_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(acc_valid) && (acc_pc == $past(acc_pc))
         && (acc_addr == $past(acc_addr))) |=> !lk_stale); // R7

    AST_SYNC_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && (inv_sync || !inv_present)) |=> (inv_done && !inv_kept)); // R8

    AST_KEEP_NEEDS_INV: assert property (@(posedge clk) disable iff (!rst_n)
        inv_kept |-> inv_done); // R2
endmodule

bind stale_line_tracker sst_checker #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_sst_checker (
    .clk(clk), .rst_n(rst_n),
    .inv_valid(inv_valid), .inv_present(inv_present), .inv_sync(inv_sync),
    .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr), .acc_sc(acc_sc),
    .lk_valid(lk_valid), .lk_stale(lk_stale),
    .inv_done(inv_done), .inv_kept(inv_kept)
);

// File: tb/test_stale_line_tracker.sv
`timescale 1ns/1ps
module test_stale_line_tracker;
    localparam int N   = 4;
    localparam int AW  = 8;
    localparam int PW  = 4;
    localparam int PCW = 8;
    localparam int L   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inv_valid = 1'b0, inv_present = 1'b0, inv_sync = 1'b0;
    logic [AW-1:0] inv_addr = '0;
    logic [PW-1:0] inv_probe = '0;
    logic          probe_valid = 1'b0;
    logic [PW-1:0] probe_id = '0;
    logic          acc_valid = 1'b0, acc_sc = 1'b0;
    logic [PCW-1:0] acc_pc = '0;
    logic [AW-1:0] acc_addr = '0;
    logic          lk_valid, lk_stale, inv_done, inv_kept, rel_valid;
    logic [AW-1:0] rel_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    stale_line_tracker #(
        .ENTRIES(N), .ADDR_W(AW), .PROBE_W(PW), .PC_W(PCW), .LIFETIME(L)
    ) i_stale_line_tracker (
        .clk(clk), .rst_n(rst_n),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_probe(inv_probe),
        .inv_present(inv_present), .inv_sync(inv_sync),
        .probe_valid(probe_valid), .probe_id(probe_id),
        .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr), .acc_sc(acc_sc),
        .lk_valid(lk_valid), .lk_stale(lk_stale),
        .inv_done(inv_done), .inv_kept(inv_kept),
        .rel_valid(rel_valid), .rel_addr(rel_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one invalidation; returns after the answering edge
    task automatic do_inv(input logic [AW-1:0] a, input logic [PW-1:0] p,
                          input bit pres, input bit syn);
        inv_valid = 1'b1; inv_addr = a; inv_probe = p;
        inv_present = pres; inv_sync = syn;
        @(negedge clk);
        inv_valid = 1'b0; inv_present = 1'b0; inv_sync = 1'b0;
    endtask

    task automatic do_acc(input logic [PCW-1:0] pc, input logic [AW-1:0] a,
                          input bit sc, output bit stale);
        acc_valid = 1'b1; acc_pc = pc; acc_addr = a; acc_sc = sc;
        @(negedge clk);
        stale = lk_stale;
        chk(lk_valid == 1'b1, "R3 lk_valid", int'(lk_valid), 1);
        acc_valid = 1'b0; acc_sc = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        bit s;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(lk_valid == 0 && inv_done == 0 && inv_kept == 0 && rel_valid == 0 && lk_stale == 0,
            "R1 outputs idle", int'({lk_valid, lk_stale, inv_done, inv_kept, rel_valid}), 0);
        do_acc(8'h11, 8'h33, 1'b0, s);
        chk(s == 0, "R1 empty table miss", int'(s), 0);

        // R2/R3: sweep lookup distance from allocation
        for (int w = 0; w <= L + 1; w++) begin
            do_inv(AW'(8'h40 + w), 4'd1, 1'b1, 1'b0);
            chk(inv_done == 1 && inv_kept == 1, "R2 allocate", int'({inv_done, inv_kept}), 3);
            idle(w);
            do_acc(PCW'(8'h80 + w), AW'(8'h40 + w), 1'b0, s);
            chk(s == (w <= L - 1), "R3 stale window", int'(s), int'(w <= L - 1));
            idle(L + N + 3);
        end

        // R4: expiry pulse timing
        do_inv(8'h5A, 4'd2, 1'b1, 1'b0);
        for (int k = 1; k <= L + 2; k++) begin
            @(negedge clk);
            chk(rel_valid == (k == L + 1), "R4 release timing", int'(rel_valid), int'(k == L + 1));
            if (k == L + 1) chk(rel_addr == 8'h5A, "R4 release addr", int'(rel_addr), 8'h5A);
        end
        do_acc(8'h95, 8'h5A, 1'b0, s);
        chk(s == 0, "R4 miss after expiry", int'(s), 0);
        idle(L + N + 3);

        // R5: probe observed again
        do_inv(8'h61, 4'd3, 1'b1, 1'b0);
        do_inv(8'h62, 4'd5, 1'b1, 1'b0);
        probe_valid = 1'b1; probe_id = 4'd3;
        @(negedge clk);
        probe_valid = 1'b0;
        chk(rel_valid == 0, "R5 no pulse yet", int'(rel_valid), 0);
        @(negedge clk);
        chk(rel_valid == 1 && rel_addr == 8'h61, "R5 probe release", int'(rel_addr), 8'h61);
        do_acc(8'h90, 8'h61, 1'b0, s);
        chk(s == 0, "R5 probed line misses", int'(s), 0);
        do_acc(8'h91, 8'h62, 1'b0, s);
        chk(s == 1, "R5 other probe kept", int'(s), 1);
        idle(L + N + 3);

        // R6: store-conditional access
        do_inv(8'h70, 4'd6, 1'b1, 1'b0);
        do_acc(8'hA0, 8'h70, 1'b1, s);
        chk(s == 0, "R6 sc not stale", int'(s), 0);
        do_acc(8'hA1, 8'h70, 1'b0, s);
        chk(s == 0, "R6 freed after sc", int'(s), 0);
        do_inv(8'h71, 4'd6, 1'b1, 1'b0);
        do_acc(8'hA2, 8'h71, 1'b0, s);
        chk(s == 1, "R6 plain load stale", int'(s), 1);
        idle(L + N + 3);

        // R7: polling detection
        do_inv(8'h72, 4'd7, 1'b1, 1'b0);
        do_acc(8'hB0, 8'h72, 1'b0, s);
        chk(s == 1, "R7 first access stale", int'(s), 1);
        do_acc(8'hB0, 8'h72, 1'b0, s);
        chk(s == 0, "R7 repeat discards", int'(s), 0);
        do_acc(8'hB1, 8'h72, 1'b0, s);
        chk(s == 0, "R7 freed after poll", int'(s), 0);
        do_inv(8'h73, 4'd7, 1'b1, 1'b0);
        do_acc(8'hB2, 8'h73, 1'b0, s);
        chk(s == 1, "R7 distinct pc one", int'(s), 1);
        do_acc(8'hB3, 8'h73, 1'b0, s);
        chk(s == 1, "R7 distinct pc two", int'(s), 1);
        idle(L + N + 3);

        // R8: sweep present/sync combinations
        for (int c = 0; c < 4; c++) begin
            bit pres = c[0];
            bit syn  = c[1];
            bit exp  = pres && !syn;
            do_inv(AW'(8'h78 + c), 4'd8, pres, syn);
            chk(inv_done == 1 && inv_kept == exp, "R8 kept flag", int'(inv_kept), int'(exp));
            do_acc(PCW'(8'hC0 + c), AW'(8'h78 + c), 1'b0, s);
            chk(s == exp, "R8 lookup after inv", int'(s), int'(exp));
        end
        idle(L + N + 3);

        // R9: eviction on a full table
        for (int e = 0; e < N; e++) begin
            do_inv(AW'(8'h20 + e), 4'd9, 1'b1, 1'b0);
            chk(rel_valid == 0, "R9 no eviction while free", int'(rel_valid), 0);
        end
        do_inv(8'h24, 4'd9, 1'b1, 1'b0);
        chk(inv_kept == 1 && rel_valid == 1, "R9 eviction pulse", int'(rel_valid), 1);
        chk(rel_addr == 8'h20, "R9 victim oldest", int'(rel_addr), 8'h20);
        do_acc(8'hD0, 8'h24, 1'b0, s);
        chk(s == 1, "R9 new line stale", int'(s), 1);
        do_acc(8'hD1, 8'h20, 1'b0, s);
        chk(s == 0, "R9 victim misses", int'(s), 0);
        do_acc(8'hD2, 8'h21, 1'b0, s);
        chk(s == 1, "R9 survivor stale", int'(s), 1);
        idle(L + N + 3);

        finish_run();
    end
endmodule